// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block is a synchronous master for a byte-wide asynchronous static RAM with a 20-bit address space. A host hands it one transfer at a time over a valid/ready request channel and gets a one-cycle response pulse when the transfer has finished. Read data comes back with that pulse. On the memory side the block drives active-low chip select, write strobe and output-enable lines, the address bus, and an 8-bit outgoing data bus with its own drive-enable. Incoming data is sampled inside the block, not by an external strobe.

Every memory timing limit is a parameter in nanoseconds. Each limit becomes a cycle count, the ceiling of the limit divided by the clock-period parameter. A read lowers chip select first, with the data driver already off. Output enable follows one cycle later. The data is sampled once both the address/select access time and the output-enable access time have elapsed. A write lowers chip select one cycle ahead of the write strobe. The write strobe is held low for the longer of the pulse-width and data-setup limits, and it rises before chip select, so the write strobe closes the window. The data driver stays on for the hold cycles after that. A recovery gap then blocks the next transfer.

Back-pressure: `req_ready` is high only while the controller is idle and the write recovery gap has run out. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must hold `req_valid` and its fields steady until then. The response channel cannot be stalled. `rsp_valid` is a single-cycle pulse and `rsp_rdata` keeps the last read byte.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A read holds `mem_we_n` at 1. It lowers `mem_ce_n` one cycle before `mem_oe_n`. `mem_dq_oe` is 0 whenever `mem_oe_n` is 0.
- R3: A read samples `mem_dq_in` only after chip select has been low for at least ceil(tACC/Tclk) cycles and output enable for at least ceil(tOE/Tclk) cycles. It returns the byte stored at `req_addr` on `rsp_rdata`, with `rsp_valid` high 2 + max(ceil(tACC/Tclk)-1, ceil(tOE/Tclk)) cycles after the accepting edge.
- R4: A write holds `mem_we_n` low for exactly max(ceil(tWP/Tclk), ceil(tDS/Tclk)) consecutive cycles, while `mem_ce_n` is low and `mem_oe_n` is high. `rsp_valid` pulses 2 + that count + ceil(tDH/Tclk) cycles after the accepting edge.
- R5: `mem_addr` and `mem_dq_out` do not change while `mem_ce_n` stays low.
- R6: `mem_dq_oe` is 1 in every cycle with `mem_we_n` low and for exactly ceil(tDH/Tclk) cycles after `mem_we_n` rises. It is 0 at all other times.
- R7: `mem_oe_n` and `mem_we_n` are never low in the same cycle.
- R8: After a write response, `req_ready` stays low for max(ceil(tWR/Tclk), ceil(tWC/Tclk) - 1 - pulse - hold) cycles. After a read response, `req_ready` is 1 at once.
- R9: A request presented while `req_ready` is low starts no memory cycle (`mem_ce_n` stays 1). It is accepted on the first edge where `req_ready` is 1.
- R10: `rsp_valid` is high for exactly one cycle per accepted transfer.
- R11: A byte written to an address is returned by a later read of that address, at both ends of the address range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host presents a transfer |
| req_ready | output | 1 | Controller can take a transfer this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| mem_addr | output | 20 | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
The inline properties check the bus-ownership rules on every cycle: write strobe and output enable are never low together, the driver is off while output enable is low, and the driver is on while the write strobe is low. They also check that address and data hold still under chip select, that chip select leads output enable by a cycle with the driver already off, and that the response and the ready signal behave as single pulses and idle-only grants. Other behaviours can only be shown by the bench scenarios, which run a memory model whose data turns valid only once the access windows have elapsed. These are the exact strobe and hold lengths, the sampling moment of a read, the response latencies, the recovery gap, the stall of a request offered during that gap, and the round trip of written data at the lowest and highest addresses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_TURN,
    ST_RD_ACC,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } seq_state_e;

  // ceiling of a nanosecond limit over the clock period
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    if (ns <= 0) return 0;
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         cnt_last,
  output logic         cnt_zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_last = (cnt_q == W'(1));
  assign cnt_zero = (cnt_q == '0);

  // R8: an expired count stays expired until reloaded
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !load) |=> cnt_zero);

endmodule

// File: rtl/sram_rsp_stage.sv
module sram_rsp_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              wr_done,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture | wr_done;
      if (capture) rsp_rdata <= dq_in;
    end
  end

  // R10: completion is a single-cycle pulse
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10: a read and a write never finish together
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && wr_done));

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 10,
  parameter int T_ACC_NS = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_WP_NS  = 55,
  parameter int T_WC_NS  = 70,
  parameter int T_DS_NS  = 30,
  parameter int T_DH_NS  = 10,
  parameter int T_WR_NS  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int C_ACC   = ns_to_cyc(T_ACC_NS, CLK_NS);
  localparam int C_OE    = ns_to_cyc(T_OE_NS, CLK_NS);
  localparam int C_WP    = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int C_WC    = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int C_DS    = ns_to_cyc(T_DS_NS, CLK_NS);
  localparam int C_WR    = ns_to_cyc(T_WR_NS, CLK_NS);
  // chip select already leads output enable by one cycle
  localparam int RD_CYC  = imax(imax(C_ACC - 1, C_OE), 1);
  localparam int WP_CYC  = imax(imax(C_WP, C_DS), 1);
  localparam int DH_CYC  = ns_to_cyc(T_DH_NS, CLK_NS);
  localparam int REC_CYC = imax(C_WR, C_WC - 1 - WP_CYC - DH_CYC);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(DH_CYC, REC_CYC));
  localparam int TW      = imax($clog2(MAX_CYC + 1), 1);

  seq_state_e st_q, st_d;
  logic          accept;
  logic          ph_load, ph_last, ph_zero;
  logic [TW-1:0] ph_val;
  logic          rec_load, rec_last, rec_zero;
  logic          capture, wr_done;

  assign req_ready = (st_q == ST_IDLE) && rec_zero;
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d     = st_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    rec_load = 1'b0;
    capture  = 1'b0;
    wr_done  = 1'b0;
    case (st_q)
      ST_IDLE:     if (accept) st_d = req_write ? ST_WR_SETUP : ST_RD_TURN;
      ST_RD_TURN: begin
        st_d    = ST_RD_ACC;
        ph_load = 1'b1;
        ph_val  = TW'(RD_CYC);
      end
      ST_RD_ACC:   if (ph_last) begin
        st_d    = ST_IDLE;
        capture = 1'b1;
      end
      ST_WR_SETUP: begin
        st_d    = ST_WR_PULSE;
        ph_load = 1'b1;
        ph_val  = TW'(WP_CYC);
      end
      ST_WR_PULSE: if (ph_last) begin
        if (DH_CYC > 0) begin
          st_d    = ST_WR_HOLD;
          ph_load = 1'b1;
          ph_val  = TW'(DH_CYC);
        end else begin
          st_d     = ST_IDLE;
          wr_done  = 1'b1;
          rec_load = 1'b1;
        end
      end
      ST_WR_HOLD:  if (ph_last) begin
        st_d     = ST_IDLE;
        wr_done  = 1'b1;
        rec_load = 1'b1;
      end
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      // strobes are registered from the next state: glitch-free pins
      mem_ce_n  <= (st_d == ST_IDLE);
      mem_oe_n  <= (st_d != ST_RD_ACC);
      mem_we_n  <= (st_d != ST_WR_PULSE);
      mem_dq_oe <= (st_d inside {ST_WR_PULSE, ST_WR_HOLD});
    end
  end

  sram_phase_timer #(.W(TW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .cnt_last (ph_last),
    .cnt_zero (ph_zero)
  );

  sram_phase_timer #(.W(TW)) u_recover (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rec_load),
    .load_val (TW'(REC_CYC)),
    .cnt_last (rec_last),
    .cnt_zero (rec_zero)
  );

  sram_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .wr_done   (wr_done),
    .dq_in     (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R7
  no_oe_we_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R6
  drive_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_ce_n));

  // R2
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && mem_we_n && !mem_ce_n));

  // R2
  oe_after_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> ($past(!mem_ce_n) && $past(!mem_dq_oe)));

  // R5
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  // R9
  ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb;
  localparam int TCLK = 10;
  // limits as given to the DUT (defaults)
  localparam int NS_ACC = 70, NS_OE = 35, NS_WP = 55, NS_WC = 70;
  localparam int NS_DS = 30, NS_DH = 10, NS_WR = 5;

  function automatic int cyc(input int ns);
    return (ns <= 0) ? 0 : (ns + TCLK - 1) / TCLK;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_ACC = cyc(NS_ACC);
  localparam int E_OE  = cyc(NS_OE);
  localparam int E_RD  = mx(E_ACC - 1, E_OE);
  localparam int E_WP  = mx(cyc(NS_WP), cyc(NS_DS));
  localparam int E_DH  = cyc(NS_DH);
  localparam int E_REC = mx(cyc(NS_WR), cyc(NS_WC) - 1 - E_WP - E_DH);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [19:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in = 8'hEE;

  int checks = 0;
  int fails  = 0;

  always #(TCLK/2) clk = ~clk;

  sram_cycle_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---- memory model and pin monitor (all at the falling edge) ----
  logic [7:0]  sram_mem [logic [19:0]];
  logic [7:0]  ref_mem  [logic [19:0]];

  function automatic logic [7:0] fill(input logic [19:0] a);
    return a[7:0] ^ a[19:12] ^ 8'hA5;
  endfunction

  int   ce_cnt = 0, oe_cnt = 0, we_run = 0, hold_run = 0;
  bit   in_hold = 0, prev_ce_low = 0, prev_we_low = 0, mon_on = 0;
  logic [19:0] prev_addr = '0;
  logic [7:0]  prev_dq = '0, wr_latch = '0;
  int   bus_clash = 0, bus_moves = 0, stray_drive = 0, turn_bad = 0;
  bit   prev_oe_low = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      ce_cnt = mem_ce_n ? 0 : ce_cnt + 1;
      oe_cnt = mem_oe_n ? 0 : oe_cnt + 1;
      if (!mem_oe_n && (mem_dq_oe || !mem_we_n)) bus_clash++;
      if (!mem_oe_n && !prev_oe_low && ce_cnt < 2) turn_bad++;
      if (!mem_ce_n && prev_ce_low &&
          (mem_addr != prev_addr || mem_dq_out != prev_dq)) bus_moves++;
      if (!mem_we_n) begin
        we_run++;
        wr_latch = mem_dq_out;
      end
      if (mem_we_n && prev_we_low) begin
        chk(we_run == E_WP, "R4 write strobe length", we_run, E_WP);
        sram_mem[mem_addr] = wr_latch;
        we_run = 0; hold_run = 0; in_hold = 1;
      end
      if (in_hold && mem_we_n) begin
        if (mem_dq_oe) hold_run++;
        else begin
          chk(hold_run == E_DH, "R6 drive hold after strobe", hold_run, E_DH);
          in_hold = 0;
        end
      end
      if (mem_dq_oe && mem_we_n && !in_hold) stray_drive++;
      // data turns valid only after both access windows
      if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe &&
          ce_cnt >= E_ACC && oe_cnt >= E_OE)
        mem_dq_in = sram_mem.exists(mem_addr) ? sram_mem[mem_addr] : fill(mem_addr);
      else
        mem_dq_in = 8'hEE;
      prev_ce_low = !mem_ce_n;
      prev_we_low = !mem_we_n;
      prev_oe_low = !mem_oe_n;
      prev_addr   = mem_addr;
      prev_dq     = mem_dq_out;
    end
  end

  // ---- one transfer; starts and ends at a falling edge ----
  task automatic xfer(input bit wr, input logic [19:0] a, input logic [7:0] d,
                      input int exp_wait, input bit stop_at_rsp);
    int waited = 0;
    int lat;
    int rec;
    logic [7:0] exp_rd;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) begin
      chk(mem_ce_n == 1'b1, "R9 no cycle while stalled", mem_ce_n, 1);
      @(negedge clk);
      waited++;
    end
    if (exp_wait >= 0)
      chk(waited == exp_wait, "R9 accepted when ready rises", waited, exp_wait);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (wr) begin
      ref_mem[a] = d;
      chk(lat == 2 + E_WP + E_DH, "R4 write response latency", lat, 2 + E_WP + E_DH);
    end else begin
      exp_rd = ref_mem.exists(a) ? ref_mem[a] : fill(a);
      chk(lat == 2 + E_RD, "R3 read response latency", lat, 2 + E_RD);
      chk(rsp_rdata == exp_rd, "R3 R11 read data", rsp_rdata, exp_rd);
      chk(req_ready == 1'b1, "R8 ready right after read", req_ready, 1);
    end
    if (stop_at_rsp) return;
    rec = req_ready ? 0 : 1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 single response pulse", rsp_valid, 0);
    while (!req_ready && rec < 100) begin
      @(negedge clk);
      rec++;
    end
    if (wr) chk(rec == E_REC, "R8 write recovery gap", rec, E_REC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: during reset
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid} == 5'b11100,
        "R1 pins in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe} == 4'b1110,
        "R1 idle pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

    // directed corners: range ends, unwritten location
    xfer(1'b1, 20'h00000, 8'h3C, 0, 0);
    xfer(1'b1, 20'hFFFFF, 8'hC3, 0, 0);
    xfer(1'b0, 20'h00000, 8'h00, 0, 0);   // R11 low end
    xfer(1'b0, 20'hFFFFF, 8'h00, 0, 0);   // R11 high end
    xfer(1'b0, 20'h12345, 8'h00, 0, 0);   // R3 never written
    // back-pressure: offer a read during the write recovery gap
    xfer(1'b1, 20'h00ABC, 8'h5A, 0, 1);
    xfer(1'b0, 20'h00ABC, 8'h00, E_REC, 0);   // R9
    // write directly after a read (no recovery after reads)
    xfer(1'b0, 20'h00ABC, 8'h00, 0, 1);
    xfer(1'b1, 20'h00ABD, 8'hFF, 0, 0);

    for (int i = 0; i < 80; i++) begin
      logic [19:0] a;
      a = {17'h0, 3'($urandom_range(0, 7))} | (($urandom_range(0, 1) == 1) ? 20'hFFFF0 : 20'h0);
      xfer(1'($urandom_range(0, 1)), a, 8'($urandom), 0, 0);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    chk(bus_clash == 0, "R7 R2 no drive fight", bus_clash, 0);
    chk(turn_bad == 0, "R2 select leads output enable", turn_bad, 0);
    chk(bus_moves == 0, "R5 address and data steady", bus_moves, 0);
    chk(stray_drive == 0, "R6 drive only in write window", stray_drive, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule